// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block decides when an analog-to-digital converter begins a conversion sequence. It accepts two kinds of start request: a one-cycle software strobe, and an external trigger pin that passes through a synchronizer. Four configuration bits select the behaviour. The first enables the external trigger. The second chooses edge or level sensitivity. The third sets the active polarity. The fourth selects continuous scanning when the trigger is disabled. A one-cycle start pulse goes to the conversion engine, and the block watches the engine's busy and done signals to know when it may start again.

A built-in stand-in engine holds busy for a programmable number of cycles after every start and then pulses done for one cycle. This keeps the block self-contained. A sticky overrun flag records edge triggers that arrive while a sequence is already running. Software clears the flag with a one-cycle strobe.

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset, start_pulse, busy, done and overrun are all 0.
- R2: With cfg_trig_en=0, the trigger pin has no effect. With cfg_scan=0, one sw_start pulse given while idle produces exactly one sequence.
- R3: With cfg_trig_en=0 and cfg_scan=1, a sw_start begins back-to-back sequences. These continue until cfg_scan is cleared or cfg_trig_en is set.
- R4: With cfg_trig_en=1 and cfg_level=0, each active edge seen while idle starts exactly one sequence. cfg_pol_high=1 selects rising edges and cfg_pol_high=0 selects falling edges.
- R5: With cfg_trig_en=1 and cfg_level=1, sequences repeat while the synchronized pin equals cfg_pol_high. cfg_pol_high=1 means high is active and 0 means low is active.
- R6: While cfg_trig_en=1, sw_start never causes a start pulse.
- R7: In edge mode, an active edge that arrives while a sequence is in progress sets overrun. It does not queue an extra sequence.
- R8: In level mode, overrun is never set. This includes the case where the pin deasserts and reasserts during a sequence.
- R9: start_pulse rises on the third rising clock edge after the pin changes. Two of those edges are the synchronizer and one is the decision register.
- R10: Each start pulse is followed one cycle later by busy. busy stays high for max(seq_len,1) cycles, and done then pulses high for one cycle as busy falls.
- R11: overrun stays set until ovr_clr is high at a clock edge. If a new overrun and a clear occur in the same cycle, the flag stays set.
- R12: Clearing cfg_trig_en during a sequence lets that sequence finish with its done pulse, and no further sequence starts.
- R13: In level mode with the trigger still active, start_pulse is high in the cycle right after the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start strobe |
| trig_pin | input | 1 | Asynchronous external trigger |
| cfg_trig_en | input | 1 | Enable the external trigger; disables software starts |
| cfg_level | input | 1 | 1 = level sensitive, 0 = edge sensitive |
| cfg_pol_high | input | 1 | 1 = rising/high active, 0 = falling/low active |
| cfg_scan | input | 1 | Continuous sequences in software mode |
| seq_len | input | LEN_W | Busy cycles per sequence (0 treated as 1) |
| ovr_clr | input | 1 | Clear strobe for the overrun flag |
| start_pulse | output | 1 | One-cycle conversion start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle sequence completion |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Each result has a fixed delay after its stimulus. A pin change shows up on start_pulse, or on overrun, three rising edges later. A software strobe shows up one edge later. busy follows start_pulse by one edge, and done comes max(seq_len,1) edges after busy rises. The bench advances its own cycle model at every rising edge and compares all four outputs at the following falling edge, so each comparison sees values that have settled for exactly the right cycle. The directed cases then count pulses over windows long enough to cover those delays.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [1:0] {
    TM_SOFT  = 2'd0,
    TM_EDGE  = 2'd1,
    TM_LEVEL = 2'd2
  } trig_mode_e;

  // Select how start requests are qualified from the two enable bits.
  function automatic trig_mode_e pick_mode(input logic trig_en, input logic level_sel);
    if (!trig_en)  return TM_SOFT;
    if (level_sel) return TM_LEVEL;
    return TM_EDGE;
  endfunction

  // The synchronized trigger sits at its active level.
  function automatic logic level_match(input logic cur, input logic pol_high);
    return cur == pol_high;
  endfunction

  // The synchronized trigger has just moved to its active level.
  function automatic logic active_edge(input logic cur, input logic prev, input logic pol_high);
    return (cur != prev) && (cur == pol_high);
  endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol_high,
  output logic lvl_active,
  output logic edge_active
);
  import adc_trig_pkg::*;

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      prev_q <= 1'b0;
    end else begin
      chain[0] <= pin;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev_q <= chain[LAST];
    end
  end

  assign lvl_active  = level_match(chain[LAST], pol_high);
  assign edge_active = active_edge(chain[LAST], prev_q, pol_high);

  // R4: while polarity holds, one transition gives a single detect cycle
  a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    edge_active |=> (!edge_active || !$stable(pol_high)));

endmodule

// File: rtl/adc_start_qual.sv
module adc_start_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_start,
  input  logic trig_en,
  input  logic level_sel,
  input  logic scan,
  input  logic lvl_active,
  input  logic edge_active,
  input  logic eng_busy,
  output logic start_pulse,
  output logic ovr_set
);
  import adc_trig_pkg::*;

  trig_mode_e mode;
  logic       idle;
  logic       want_start;
  logic       scan_run_q;

  assign mode = pick_mode(trig_en, level_sel);
  assign idle = !eng_busy && !start_pulse;

  always_comb begin
    unique case (mode)
      TM_SOFT:  want_start = idle && (sw_start || scan_run_q);
      TM_EDGE:  want_start = idle && edge_active;
      TM_LEVEL: want_start = idle && lvl_active;
      default:  want_start = 1'b0;
    endcase
  end

  assign ovr_set = (mode == TM_EDGE) && edge_active && !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      scan_run_q  <= 1'b0;
    end else begin
      start_pulse <= want_start;
      if (mode == TM_SOFT && scan) scan_run_q <= scan_run_q || sw_start;
      else                         scan_run_q <= 1'b0;
    end
  end

  // R6: with the trigger enabled, a start needs a trigger event
  a_r6_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && $past(trig_en)) |-> $past(edge_active || lvl_active));
  // R10: never start on top of a running sequence
  a_r10_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !eng_busy);
  // R7: an overrun only arises while a sequence is in flight
  a_r7_ovr_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |-> (eng_busy || start_pulse));

endmodule

// File: rtl/adc_sticky_flag.sv
module adc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R11: a set beats a clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R11: a clear alone empties the flag
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);

endmodule

// File: rtl/adc_seq_stub.sv
module adc_seq_stub #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             done
);
  logic [LEN_W-1:0] remain_q;

  // A zero length still occupies one busy cycle.
  function automatic logic [LEN_W-1:0] first_count(input logic [LEN_W-1:0] l);
    return (l == '0) ? '0 : l - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      remain_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        remain_q <= first_count(len);
      end else if (busy) begin
        if (remain_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          remain_q <= remain_q - 1'b1;
        end
      end
    end
  end

  // R10: busy follows every start
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R10: done lasts one cycle and closes a busy period
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             trig_pin,
  input  logic             cfg_trig_en,
  input  logic             cfg_level,
  input  logic             cfg_pol_high,
  input  logic             cfg_scan,
  input  logic [LEN_W-1:0] seq_len,
  input  logic             ovr_clr,
  output logic             start_pulse,
  output logic             busy,
  output logic             done,
  output logic             overrun
);
  logic evt_level;
  logic evt_edge;
  logic ovr_set;

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin         (trig_pin),
    .pol_high    (cfg_pol_high),
    .lvl_active  (evt_level),
    .edge_active (evt_edge)
  );

  adc_start_qual u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_start    (sw_start),
    .trig_en     (cfg_trig_en),
    .level_sel   (cfg_level),
    .scan        (cfg_scan),
    .lvl_active  (evt_level),
    .edge_active (evt_edge),
    .eng_busy    (busy),
    .start_pulse (start_pulse),
    .ovr_set     (ovr_set)
  );

  adc_sticky_flag u_ovr (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ovr_set),
    .clr   (ovr_clr),
    .q     (overrun)
  );

  adc_seq_stub #(.LEN_W(LEN_W)) u_eng (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_pulse),
    .len   (seq_len),
    .busy  (busy),
    .done  (done)
  );

  // R8: level sensitivity never raises the flag
  a_r8_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_trig_en && cfg_level && !overrun) |=> !overrun);
  // R13: a start pulse is never repeated back to back
  a_r13_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

endmodule

// File: tb/sim_adc_start_ctrl.sv
module sim_adc_start_ctrl;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_start = 0, trig_pin = 0, cfg_trig_en = 0, cfg_level = 0;
  logic cfg_pol_high = 0, cfg_scan = 0, ovr_clr = 0;
  logic [LW-1:0] seq_len = 8'd3;
  logic start_pulse, busy, done, overrun;

  int checks = 0, failures = 0, cyc = 0;
  int n_start = 0, n_done = 0, n_ovr_hi = 0;

  always #5 clk = ~clk;

  adc_start_ctrl #(.LEN_W(LW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .trig_pin(trig_pin),
    .cfg_trig_en(cfg_trig_en), .cfg_level(cfg_level), .cfg_pol_high(cfg_pol_high),
    .cfg_scan(cfg_scan), .seq_len(seq_len), .ovr_clr(ovr_clr),
    .start_pulse(start_pulse), .busy(busy), .done(done), .overrun(overrun));

  // ---------------- reference model, advanced on each rising edge
  bit m_p1, m_p2, m_old, m_st, m_busy, m_done, m_ovr, m_run;
  int m_left;
  string m_tag = "R2";

  function automatic bit f_go(bit en, bit lvl, bit pol, bit sw, bit run,
                              bit cur, bit old, bit free);
    if (!free) return 0;
    if (!en)   return sw || run;
    if (lvl)   return cur == pol;
    return (cur != old) && (cur == pol);
  endfunction

  function automatic bit f_ovr(bit en, bit lvl, bit pol, bit cur, bit old, bit free, bit was);
    bit hit = en && !lvl && !free && (cur != old) && (cur == pol);
    return hit ? 1'b1 : (ovr_clr ? 1'b0 : was);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (n_start < 1000000 && start_pulse) n_start++;
    if (done) n_done++;
    if (overrun) n_ovr_hi++;
    if (!rst_n) begin
      {m_p1, m_p2, m_old, m_st, m_busy, m_done, m_ovr, m_run} = '0;
      m_left = 0;
    end else begin
      bit free, go, nxt_busy, nxt_done;
      int nxt_left;
      free = !m_busy && !m_st;
      go = f_go(cfg_trig_en, cfg_level, cfg_pol_high, sw_start, m_run, m_p2, m_old, free);
      m_ovr = f_ovr(cfg_trig_en, cfg_level, cfg_pol_high, m_p2, m_old, free, m_ovr);
      nxt_busy = m_busy; nxt_done = 0; nxt_left = m_left;
      if (m_st) begin
        nxt_busy = 1; nxt_left = (seq_len == 0) ? 1 : int'(seq_len);
      end
      if (!m_st && m_busy) begin
        nxt_left = m_left - 1;
        if (nxt_left == 0) begin nxt_busy = 0; nxt_done = 1; end
      end
      m_run  = (!cfg_trig_en && cfg_scan) ? (m_run || sw_start) : 1'b0;
      m_old  = m_p2; m_p2 = m_p1; m_p1 = trig_pin;
      m_st   = go; m_busy = nxt_busy; m_done = nxt_done; m_left = nxt_left;
      m_tag  = !cfg_trig_en ? "R2" : (cfg_level ? "R5" : "R4");
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle compare on the falling edge
  always @(negedge clk) if (rst_n) begin
    chk(m_tag, "start_pulse", start_pulse, m_st);
    chk("R10", "busy", busy, m_busy);
    chk("R10", "done", done, m_done);
    chk("R7", "overrun", overrun, m_ovr);
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(bit en, bit lvl, bit pol, bit scan, int len);
    @(negedge clk);
    cfg_trig_en = en; cfg_level = lvl; cfg_pol_high = pol; cfg_scan = scan;
    seq_len = LW'(len);
  endtask

  task automatic settle();  // quiet configuration, let the engine drain
    cfg(0, 0, 0, 0, 3);
    sw_start = 0;
    cycles(30);
    ovr_clr = 1; cycles(1); ovr_clr = 0;
  endtask

  // watchdog
  initial begin
    wait (cyc >= 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    cycles(3);
    chk("R1", "start after reset", start_pulse, 0);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "overrun after reset", overrun, 0);
    rst_n = 1;
    cycles(2);

    // R2: pin ignored, single sequence per strobe
    settle(); trig_pin = 0;
    n_start = 0;
    for (int i = 0; i < 10; i++) begin trig_pin = ~trig_pin; cycles(2); end
    cycles(5);
    chk("R2", "starts from pin with trigger off", n_start, 0);
    n_start = 0; sw_start = 1; cycles(1); sw_start = 0; cycles(30);
    chk("R2", "starts from one strobe", n_start, 1);

    // R3: continuous software scan, period 1+3+1
    cfg(0, 0, 0, 1, 3);
    n_start = 0; sw_start = 1; cycles(1); sw_start = 0; cycles(40);
    chk("R3", "scan starts >= 6", int'(n_start >= 6), 1);
    cfg_scan = 0; cycles(10); n_start = 0; cycles(20);
    chk("R3", "scan stops", n_start, 0);

    // R6: software strobes ignored while trigger enabled (edge and level)
    settle(); trig_pin = 0; cfg(1, 0, 1, 1, 3); cycles(5);
    n_start = 0;
    for (int i = 0; i < 5; i++) begin sw_start = 1; cycles(1); sw_start = 0; cycles(3); end
    cfg_level = 1; cycles(2);
    for (int i = 0; i < 5; i++) begin sw_start = 1; cycles(1); sw_start = 0; cycles(3); end
    chk("R6", "starts from strobes", n_start, 0);

    // R9: pin to start latency, rising edge
    cfg(1, 0, 1, 0, 4); cycles(5);
    trig_pin = 1;
    cycles(1); chk("R9", "start after edge 1", start_pulse, 0);
    cycles(1); chk("R9", "start after edge 2", start_pulse, 0);
    cycles(1); chk("R9", "start after edge 3", start_pulse, 1);
    cycles(20);
    // R4: falling edge with polarity 0 starts one sequence
    cfg(1, 0, 0, 0, 4); cycles(5);
    n_start = 0; trig_pin = 0; cycles(20);
    chk("R4", "falling edge starts", n_start, 1);

    // R7: edge during busy sets overrun, no queued sequence
    settle(); trig_pin = 0; cfg(1, 0, 1, 0, 12); cycles(5);
    n_start = 0; trig_pin = 1; cycles(6); trig_pin = 0; cycles(2); trig_pin = 1; cycles(25);
    chk("R7", "overrun set", overrun, 1);
    chk("R7", "no queued start", n_start, 1);
    ovr_clr = 1; cycles(1); ovr_clr = 0;
    chk("R11", "overrun cleared", overrun, 0);

    // R11: set wins over a held clear
    trig_pin = 0; cycles(5);
    trig_pin = 1; cycles(6); ovr_clr = 1; n_ovr_hi = 0;
    trig_pin = 0; cycles(2); trig_pin = 1; cycles(8); ovr_clr = 0;
    chk("R11", "overrun seen under clear", int'(n_ovr_hi >= 1), 1);
    cycles(20);

    // R8: level deassert/reassert inside a sequence
    settle(); trig_pin = 0; cfg(1, 1, 1, 0, 12); cycles(5);
    trig_pin = 1; cycles(6); trig_pin = 0; cycles(2); trig_pin = 1; cycles(12);
    chk("R8", "no overrun in level mode", overrun, 0);

    // R13: restart right after done while level active
    begin
      int seen = 0;
      bit prev_done = 0;
      for (int i = 0; i < 60; i++) begin
        cycles(1);
        if (prev_done) begin chk("R13", "start after done", start_pulse, 1); seen++; end
        prev_done = done;
      end
      chk("R13", "restarts observed", int'(seen >= 2), 1);
    end
    chk("R5", "level high runs", busy | start_pulse | done, 1);

    // R12: drop trigger enable mid sequence
    while (!busy) cycles(1);
    cfg_trig_en = 0; n_start = 0; n_done = 0;
    cycles(30);
    chk("R12", "in-flight sequence finishes", n_done, 1);
    chk("R12", "no new starts", n_start, 0);

    // R5: active-low level
    settle(); trig_pin = 1; cfg(1, 1, 0, 0, 2); cycles(5);
    n_start = 0; trig_pin = 0; cycles(20); trig_pin = 1; cycles(15);
    chk("R5", "active-low repeats", int'(n_start >= 3), 1);

    // constrained random phases, checked by the cycle model
    for (int p = 0; p < 40; p++) begin
      cfg($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
          $urandom_range(0, 1), $urandom_range(0, 6));
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        if ($urandom_range(0, 5) == 0) trig_pin = ~trig_pin;
        sw_start = ($urandom_range(0, 9) == 0);
        ovr_clr  = ($urandom_range(0, 19) == 0);
      end
    end
    sw_start = 0; ovr_clr = 0;
    cycles(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule